// File: doc/BRIEF.md
# Hot-Swap Supervisor Reset Sequencer

This block is the digital control core of a hot-swap card power supervisor. It receives undervoltage flags that comparators have already digitised for the host and card supplies, two over-current trip flags, the host's active-low reset, a power-enable input and a static supply-select strap. From these it drives the card's status outputs (healthy and signal-valid, both active low), the enable for the high-side supply drivers, and a complementary pair of local reset outputs.

A glitch filter on the host reset means a low pulse only counts if it lasts a set number of clock cycles. Every reset cause reloads a stretch counter, so the local reset is held for a minimum period after the last cause goes away. An over-current trip is latched and keeps the drivers off until power-enable is taken low and then high again. A fault on the main supply only matters when the strap selects 5 V or mixed mode. Every input is asynchronous and passes through a two-flop synchronizer.

Top module: `hsSupervisor`

## Requirements
- R1: The host reset input (active low) counts as a reset cause only after its synchronized value has been low for FILT_CYCLES consecutive cycles. A low pulse of FILT_CYCLES-1 cycles at the port never asserts the local reset.
- R2: The local reset outputs are active (rstLocalN low and rstLocal high) while any reset cause is present. They stay active for STRETCH_CYCLES more cycles after the last cycle in which a synchronized cause was seen. A host reset that is held low keeps them active for as long as it is held.
- R3: A host undervoltage flag (1 = undervoltage) drives drvEn low, asserts the local reset and de-asserts both status outputs (driven high).
- R4: A card 3.3 V or card 5 V undervoltage flag (1 = undervoltage) asserts the local reset and drives both status outputs high. It does not change drvEn.
- R5: A low pwrEn drives drvEn low and asserts the local reset.
- R6: A high level on either over-current input latches drvEn low. The latch clears only on a synchronized low-to-high transition of pwrEn, and a trip that is still present at that transition wins over the clear.
- R7: When strap3v is 0, a main-supply undervoltage flag drives drvEn low, asserts the local reset and drives the status outputs high. When strap3v is 1, that flag has no effect on any output.
- R8: healthyN and sigValidN are low only when no reset cause is present, the stretch has ended and no breaker trip is latched.
- R9: A cause that clears during a stretch does not shorten it. Every new cause, even one lasting a single cycle, restarts the full STRETCH_CYCLES period.
- R10: While rstN is low, and straight after it is released, drvEn is low, the local reset is active, the status outputs are high and the breaker latch is clear.
- R11: Every input passes through two synchronizer flops. A change at a level input reaches the outputs after the second rising clock edge, and is not visible after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Power-on reset, asynchronous, active low |
| hostRstInN | input | 1 | Host reset request, active low, asynchronous |
| pwrEn | input | 1 | Card power enable from the host |
| hostUv | input | 1 | Host 3.3 V undervoltage flag |
| cardUv3 | input | 1 | Card 3.3 V undervoltage flag |
| cardUv5 | input | 1 | Card 5 V undervoltage flag |
| mainUv | input | 1 | Main supply undervoltage flag |
| ocLow | input | 1 | Over-current trip, low-voltage rail |
| ocHigh | input | 1 | Over-current trip, high-voltage rail |
| strap3v | input | 1 | Supply-select strap, 1 = 3.3 V mode |
| drvEn | output | 1 | High-side driver enable |
| healthyN | output | 1 | Card healthy, active low |
| sigValidN | output | 1 | Signal valid, active low |
| rstLocalN | output | 1 | Local reset, active low |
| rstLocal | output | 1 | Local reset, active high |

## Verification
The hardest behaviour to reach from the ports is the interplay of the latched breaker with a pwrEn cycle that is still inside a running stretch. During that cycle drvEn must come back one cycle after the synchronized rising edge, while the status outputs stay high until the stretch ends. Reaching it takes a trip, a low pwrEn and a return to high, all in the right order, with no new cause arriving in between. Directed sequences build this case along with the exact-length filter pulses and a restart in mid-stretch. A long run of seeded random toggles, with rare pwrEn and trip events, then checks every output on every cycle against a cycle-level reference model in the bench.

// File: rtl/hsSupPkg.sv
package hsSupPkg;

  // Synchronized copy of every asynchronous input.
  typedef struct packed {
    logic hostRstN;
    logic pwrEn;
    logic hostUv;
    logic cardUv3;
    logic cardUv5;
    logic mainUv;
    logic ocLow;
    logic ocHigh;
    logic strap3v;
  } syncIn_t;

  localparam int SYNC_W = $bits(syncIn_t);

  // Synchronizer reset values: host reset released, power disabled.
  localparam syncIn_t SYNC_RST = '{hostRstN: 1'b1, default: 1'b0};

  // Strobes from control to datapath.
  typedef struct packed {
    logic reload;     // load full stretch period
    logic step;       // count stretch down
    logic setTrip;    // set breaker latch
    logic clearTrip;  // clear breaker latch
  } strobe_t;

endpackage

// File: rtl/hsSupDatapath.sv
module hsSupDatapath
  import hsSupPkg::*;
#(
  parameter int FILT_CYCLES    = 4,
  parameter int STRETCH_CYCLES = 20000
) (
  input  logic    clk,
  input  logic    rstN,
  input  syncIn_t rawIn,
  input  strobe_t strb,
  output syncIn_t syncd,
  output logic    hostLowFilt,
  output logic    stretchBusy,
  output logic    tripped,
  output logic    pwrEnRise
);

  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [FW-1:0] FILT_MAX = FW'(FILT_CYCLES);
  localparam logic [SW-1:0] STRETCH_MAX = SW'(STRETCH_CYCLES);
  localparam logic [SYNC_W-1:0] RST_VEC = SYNC_RST;

  logic [SYNC_W-1:0] rawVec, stage1, stage2;
  logic [FW-1:0] lowCnt;
  logic [SW-1:0] stretchCnt;
  logic pwrEnPrev;

  assign rawVec = rawIn;

  // Two-flop synchronizer per input bit.
  for (genvar i = 0; i < SYNC_W; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i] <= RST_VEC[i];
        stage2[i] <= RST_VEC[i];
      end else begin
        stage1[i] <= rawVec[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign syncd = syncIn_t'(stage2);

  // Host reset glitch filter: saturating count of consecutive low samples.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (syncd.hostRstN) begin
      lowCnt <= '0;
    end else if (lowCnt != FILT_MAX) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign hostLowFilt = (lowCnt == FILT_MAX);

  // Minimum-width reset stretcher.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stretchCnt <= STRETCH_MAX;
    end else if (strb.reload) begin
      stretchCnt <= STRETCH_MAX;
    end else if (strb.step) begin
      stretchCnt <= stretchCnt - 1'b1;
    end
  end

  assign stretchBusy = (stretchCnt != '0);

  // Breaker latch and power-enable edge detect.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripped   <= 1'b0;
      pwrEnPrev <= 1'b0;
    end else begin
      pwrEnPrev <= syncd.pwrEn;
      if (strb.setTrip) begin
        tripped <= 1'b1;
      end else if (strb.clearTrip) begin
        tripped <= 1'b0;
      end
    end
  end

  assign pwrEnRise = syncd.pwrEn & ~pwrEnPrev;

  // R1: the filter output rises only after a low synchronized sample.
  p_filter_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostLowFilt) |-> $past(!syncd.hostRstN));

  // R9: a reload strobe always leaves the full period in the counter.
  p_reload_full_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (stretchCnt == STRETCH_MAX));

  // R6: the breaker latch only falls after a power-enable rise.
  p_trip_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tripped) |-> $past(pwrEnRise));

endmodule

// File: rtl/hsSupControl.sv
module hsSupControl
  import hsSupPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  syncIn_t syncd,
  input  logic    hostLowFilt,
  input  logic    stretchBusy,
  input  logic    tripped,
  input  logic    pwrEnRise,
  output strobe_t strb,
  output logic    drvEn,
  output logic    rstActive,
  output logic    statusOk
);

  logic mainFault;
  logic resetCause;

  // The main supply counts only in 5 V / mixed mode.
  assign mainFault  = syncd.mainUv & ~syncd.strap3v;

  assign resetCause = hostLowFilt | syncd.hostUv | syncd.cardUv3 |
                      syncd.cardUv5 | mainFault | ~syncd.pwrEn;

  always_comb begin
    strb.reload    = resetCause;
    strb.step      = ~resetCause & stretchBusy;
    strb.setTrip   = syncd.ocLow | syncd.ocHigh;
    strb.clearTrip = pwrEnRise;
  end

  assign rstActive = resetCause | stretchBusy;
  assign drvEn     = syncd.pwrEn & ~tripped & ~syncd.hostUv & ~mainFault;
  assign statusOk  = ~rstActive & ~tripped;

  // R6: a latched trip keeps the drivers off.
  p_trip_gate_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    tripped |-> !drvEn);

  // R5: power-enable low keeps the drivers off and holds reset.
  p_pwr_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    !syncd.pwrEn |-> (!drvEn && rstActive));

  // R8: status is only good with the stretcher idle and no trip.
  p_status_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusOk |-> (!stretchBusy && !tripped));

endmodule

// File: rtl/hsSupervisor.sv
module hsSupervisor
  import hsSupPkg::*;
#(
  parameter int FILT_CYCLES    = 4,
  parameter int STRETCH_CYCLES = 20000
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostRstInN,
  input  logic pwrEn,
  input  logic hostUv,
  input  logic cardUv3,
  input  logic cardUv5,
  input  logic mainUv,
  input  logic ocLow,
  input  logic ocHigh,
  input  logic strap3v,
  output logic drvEn,
  output logic healthyN,
  output logic sigValidN,
  output logic rstLocalN,
  output logic rstLocal
);

  syncIn_t rawIn, syncd;
  strobe_t strb;
  logic hostLowFilt, stretchBusy, tripped, pwrEnRise;
  logic rstActive, statusOk;

  always_comb begin
    rawIn.hostRstN = hostRstInN;
    rawIn.pwrEn    = pwrEn;
    rawIn.hostUv   = hostUv;
    rawIn.cardUv3  = cardUv3;
    rawIn.cardUv5  = cardUv5;
    rawIn.mainUv   = mainUv;
    rawIn.ocLow    = ocLow;
    rawIn.ocHigh   = ocHigh;
    rawIn.strap3v  = strap3v;
  end

  hsSupDatapath #(
    .FILT_CYCLES   (FILT_CYCLES),
    .STRETCH_CYCLES(STRETCH_CYCLES)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .rawIn      (rawIn),
    .strb       (strb),
    .syncd      (syncd),
    .hostLowFilt(hostLowFilt),
    .stretchBusy(stretchBusy),
    .tripped    (tripped),
    .pwrEnRise  (pwrEnRise)
  );

  hsSupControl ctl (
    .clk        (clk),
    .rstN       (rstN),
    .syncd      (syncd),
    .hostLowFilt(hostLowFilt),
    .stretchBusy(stretchBusy),
    .tripped    (tripped),
    .pwrEnRise  (pwrEnRise),
    .strb       (strb),
    .drvEn      (drvEn),
    .rstActive  (rstActive),
    .statusOk   (statusOk)
  );

  assign rstLocal  = rstActive;
  assign rstLocalN = ~rstActive;
  assign healthyN  = ~statusOk;
  assign sigValidN = ~statusOk;

  // R2: the two local reset outputs are always complementary.
  p_rst_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    rstLocal != rstLocalN);

  // R8: good status never coexists with an active local reset.
  p_status_vs_rst_r8: assert property (@(posedge clk) disable iff (!rstN)
    !healthyN |-> !rstLocal);

endmodule

// File: tb/hsSupervisor_test.sv
module hsSupervisor_test;
  import hsSupPkg::*;

  localparam int FILT = 4;
  localparam int STR  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  syncIn_t drv;
  logic drvEn, healthyN, sigValidN, rstLocalN, rstLocal;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  hsSupervisor #(.FILT_CYCLES(FILT), .STRETCH_CYCLES(STR)) uut (
    .clk(clk), .rstN(rstN),
    .hostRstInN(drv.hostRstN), .pwrEn(drv.pwrEn), .hostUv(drv.hostUv),
    .cardUv3(drv.cardUv3), .cardUv5(drv.cardUv5), .mainUv(drv.mainUv),
    .ocLow(drv.ocLow), .ocHigh(drv.ocHigh), .strap3v(drv.strap3v),
    .drvEn(drvEn), .healthyN(healthyN), .sigValidN(sigValidN),
    .rstLocalN(rstLocalN), .rstLocal(rstLocal)
  );

  // Cycle-level reference model written from the requirements.
  syncIn_t m1, m2;
  int  mLow, mCnt;
  logic mTrip, mPrev;

  function automatic logic mCause();
    return (mLow == FILT) | m2.hostUv | m2.cardUv3 | m2.cardUv5 |
           (m2.mainUv & ~m2.strap3v) | ~m2.pwrEn;
  endfunction
  function automatic logic expRst();
    return mCause() | (mCnt != 0);
  endfunction
  function automatic logic expGate();
    return m2.pwrEn & ~mTrip & ~m2.hostUv & ~(m2.mainUv & ~m2.strap3v);
  endfunction
  function automatic logic expOkN();
    return ~(~expRst() & ~mTrip);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= SYNC_RST; m2 <= SYNC_RST;
      mLow <= 0; mCnt <= STR; mTrip <= 1'b0; mPrev <= 1'b0;
    end else begin
      m1 <= drv; m2 <= m1;
      mLow <= m2.hostRstN ? 0 : ((mLow == FILT) ? FILT : mLow + 1);
      mCnt <= mCause() ? STR : ((mCnt != 0) ? mCnt - 1 : 0);
      mTrip <= (m2.ocLow | m2.ocHigh) ? 1'b1 :
               ((m2.pwrEn & ~mPrev) ? 1'b0 : mTrip);
      mPrev <= m2.pwrEn;
      cycles <= cycles + 1;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cycles, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R5/R6 drvEn model",     drvEn,     expGate());
    chk("R2 rstLocal model",     rstLocal,  expRst());
    chk("R2 rstLocalN model",    rstLocalN, ~expRst());
    chk("R8 healthyN model",     healthyN,  expOkN());
    chk("R8 sigValidN model",    sigValidN, expOkN());
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic settle();
    step(STR + 8);
    chk("R8 settled healthyN", healthyN, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240601));
    drv = SYNC_RST;
    drv.pwrEn = 1'b0;
    repeat (3) @(negedge clk);
    // R10: state during reset
    chk("R10 drvEn in reset", drvEn, 1'b0);
    chk("R10 rstLocal in reset", rstLocal, 1'b1);
    chk("R10 healthyN in reset", healthyN, 1'b1);
    rstN = 1'b1;
    step(1);
    chk("R10 drvEn after reset", drvEn, 1'b0);
    chk("R10 rstLocalN after reset", rstLocalN, 1'b0);
    drv.pwrEn = 1'b1;
    step(STR + 5);
    chk("R10 drvEn up, no trip latched", drvEn, 1'b1);
    chk("R8 status good", sigValidN, 1'b0);

    // R11 and R4: card 3.3 V flag, two-flop latency
    drv.cardUv3 = 1'b1;
    step(1);
    chk("R11 not seen after one edge", rstLocal, 1'b0);
    step(1);
    chk("R11 seen after two edges", rstLocal, 1'b1);
    chk("R4 drvEn unaffected", drvEn, 1'b1);
    chk("R4 healthyN high", healthyN, 1'b1);
    drv.cardUv3 = 1'b0;
    step(STR + 1);
    chk("R2 still stretched", rstLocal, 1'b1);
    step(1);
    chk("R2 stretch ended", rstLocal, 1'b0);
    settle();

    // R1: one cycle short of the filter length is ignored
    drv.hostRstN = 1'b0;
    step(FILT - 1);
    drv.hostRstN = 1'b1;
    for (int i = 0; i < FILT + 4; i++) begin
      step(1);
      chk("R1 short pulse ignored", rstLocal, 1'b0);
    end
    // R1: exact filter length is accepted
    drv.hostRstN = 1'b0;
    step(FILT);
    drv.hostRstN = 1'b1;
    step(3);
    chk("R1 full pulse accepted", rstLocal, 1'b1);
    settle();
    // R2: held host reset extends the output
    drv.hostRstN = 1'b0;
    step(3 * STR);
    chk("R2 held host reset", rstLocalN, 1'b0);
    drv.hostRstN = 1'b1;
    step(STR + 2);
    chk("R2 stretch after host release", rstLocal, 1'b1);
    step(4);
    chk("R2 released", rstLocal, 1'b0);
    settle();

    // R3: host undervoltage
    drv.hostUv = 1'b1;
    step(2);
    chk("R3 drvEn off", drvEn, 1'b0);
    chk("R3 reset on", rstLocal, 1'b1);
    chk("R3 sigValidN high", sigValidN, 1'b1);
    drv.hostUv = 1'b0;
    settle();

    // R7: main supply counts in 5 V mode, ignored in 3.3 V mode
    drv.mainUv = 1'b1;
    step(2);
    chk("R7 5V mode drvEn off", drvEn, 1'b0);
    chk("R7 5V mode reset on", rstLocal, 1'b1);
    drv.mainUv = 1'b0;
    settle();
    drv.strap3v = 1'b1;
    step(3);
    drv.mainUv = 1'b1;
    step(4);
    chk("R7 3V mode drvEn kept", drvEn, 1'b1);
    chk("R7 3V mode no reset", rstLocal, 1'b0);
    chk("R7 3V mode healthyN low", healthyN, 1'b0);
    drv.mainUv = 1'b0;
    drv.strap3v = 1'b0;
    settle();

    // R6: breaker latch and power-enable cycle
    drv.ocLow = 1'b1;
    step(1);
    drv.ocLow = 1'b0;
    step(2);
    chk("R6 trip latched drvEn off", drvEn, 1'b0);
    step(10);
    chk("R6 trip stays latched", drvEn, 1'b0);
    chk("R8 healthyN high while tripped", healthyN, 1'b1);
    drv.pwrEn = 1'b0;
    step(3);
    drv.pwrEn = 1'b1;
    step(2);
    chk("R6 not yet cleared", drvEn, 1'b0);
    step(1);
    chk("R6 cleared by pwrEn cycle", drvEn, 1'b1);
    chk("R8 status waits for stretch", healthyN, 1'b1);
    // R6: trip present at the rise wins
    settle();
    drv.ocHigh = 1'b1;
    drv.pwrEn  = 1'b0;
    step(3);
    drv.pwrEn = 1'b1;
    step(6);
    chk("R6 persistent trip wins", drvEn, 1'b0);
    drv.ocHigh = 1'b0;
    drv.pwrEn  = 1'b0;
    step(3);
    drv.pwrEn = 1'b1;
    settle();
    // R5: low power enable
    drv.pwrEn = 1'b0;
    step(2);
    chk("R5 drvEn off", drvEn, 1'b0);
    chk("R5 reset on", rstLocal, 1'b1);
    drv.pwrEn = 1'b1;
    settle();

    // R9: a single-cycle cause in mid-stretch restarts the period
    drv.cardUv5 = 1'b1;
    step(3);
    drv.cardUv5 = 1'b0;
    step(STR / 2);
    drv.cardUv5 = 1'b1;
    step(1);
    drv.cardUv5 = 1'b0;
    step(STR + 1);
    chk("R9 full restart", rstLocal, 1'b1);
    step(1);
    chk("R9 ends after restart", rstLocal, 1'b0);
    settle();

    // Seeded random phase checked every cycle against the model.
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(99) < 8)  drv.hostRstN = ~drv.hostRstN;
      if ($urandom_range(199) < 2) drv.pwrEn    = ~drv.pwrEn;
      if ($urandom_range(99) < 2)  drv.hostUv   = ~drv.hostUv;
      if ($urandom_range(99) < 2)  drv.cardUv3  = ~drv.cardUv3;
      if ($urandom_range(99) < 2)  drv.cardUv5  = ~drv.cardUv5;
      if ($urandom_range(99) < 3)  drv.mainUv   = ~drv.mainUv;
      if ($urandom_range(299) < 2) drv.ocLow    = ~drv.ocLow;
      if ($urandom_range(299) < 2) drv.ocHigh   = ~drv.ocHigh;
      if ($urandom_range(199) < 1) drv.strap3v  = ~drv.strap3v;
      step(1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule